// File: doc/BRIEF.md
# Programmable Phase-Skew Clock Bank Generator

This block turns one fast tick clock, whose period is one skew time unit, into four banks of clock outputs. Each bank has two outputs, and both outputs of a bank always carry the same waveform. A free-running period counter divides the tick clock into nominal periods. A range-select input sets the period length to 32, 16 or 8 ticks, and every bank derives its waveform from the shared counter.

Each bank has a 4-bit code made of two three-level digits. On the first two banks the code picks a phase offset of -4 to +4 ticks against the zero-skew clock. The last two banks use a step of two ticks, covering -6 to +6. On these two banks the lowest code selects divide-by-2. The highest code selects divide-by-4 on the third bank and an inverted clock on the fourth. Code and range changes are held until the period counter wraps, so a change never produces a runt pulse.

Top module: `clkskew_top`

## Requirements
- R1: Each 4-bit bank code is two three-level digits. Bits [3:2] are the first digit and bits [1:0] the second. A digit value of 2'b00 means low (0), 2'b10 means high (2), and 2'b01 or 2'b11 means mid (1). The code index is idx = 3*first + second, giving 0..8.
- R2: `range_sel` sets the nominal period MF in ticks: 2'b00 gives 32, 2'b10 gives 8, and 2'b01 or 2'b11 gives 16. The tick counter runs 0..MF-1 and then wraps to 0.
- R3: Banks 0 and 1 apply a skew s = idx-4 ticks. An output is high when ((tick - s) mod MF) < MF/2, so it rises at tick s mod MF with a 50% duty cycle.
- R4: On banks 2 and 3, idx 1..7 apply a skew s = 2*(idx-4) ticks, using the same waveform rule as R3.
- R5: On banks 2 and 3, idx 0 selects divide-by-2. The output is high through every period whose period count is even and low through every odd one.
- R6: On bank 2, idx 8 selects divide-by-4. The output is high in periods whose count mod 4 is 0 or 1 and low in the other two.
- R7: On bank 3, idx 8 selects the inverted clock. The output is low when tick < MF/2 and high otherwise.
- R8: The two outputs of a bank are always equal. Bank b drives `clk_out[2b+1:2b]` and is controlled by `bank_code[4b+3:4b]`.
- R9: A change to `range_sel` or to a bank code takes effect only at the first tick after a tick of MF-1. Until then the previous setting stays in force.
- R10: A synchronous active-high reset loads the tick counter and the period count to 0 and takes the code and range inputs at once. After reset a zero-skew bank output is high from tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one period is one skew time unit |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Three-level range select (ticks per nominal period) |
| bank_code | input | 16 | Four 4-bit bank codes; bank b at bits [4b+3:4b] |
| clk_out | output | 8 | Bank outputs; bank b at bits [2b+1:2b] |

## Verification
Every code index is swept on every bank under each of the three ranges. This separates the sign of a skew, the one-tick step from the two-tick step, and the shift caused by a shorter period. The divide and invert codes run for at least four periods, so divide-by-2, divide-by-4 and inversion each produce a distinct waveform. Codes that use the spare digit value 2'b11 must match their mid-level equivalents. Mid-period code and range changes, and a reset in the middle of a run, show whether updates wait for the wrap and whether reset restarts the phase at tick 0.

// File: rtl/clkskew_pkg.sv
package clkskew_pkg;

    localparam int TICKS_LO  = 32;
    localparam int TICKS_MID = 16;
    localparam int TICKS_HI  = 8;
    localparam int CW        = $clog2(TICKS_LO);

    typedef enum logic [1:0] {
        MODE_SKEW = 2'd0,
        MODE_DIV2 = 2'd1,
        MODE_DIV4 = 2'd2,
        MODE_INV  = 2'd3
    } bank_mode_e;

    typedef struct packed {
        bank_mode_e        mode;
        logic signed [3:0] skew;
    } bank_cfg_t;

    // three-level digit to its value; the spare encoding counts as mid
    function automatic int lvl_val(input logic [1:0] d);
        if (d == 2'b00) return 0;
        if (d == 2'b10) return 2;
        return 1;
    endfunction

    function automatic logic [CW:0] ticks_of(input logic [1:0] r);
        if (r == 2'b00) return (CW+1)'(TICKS_LO);
        if (r == 2'b10) return (CW+1)'(TICKS_HI);
        return (CW+1)'(TICKS_MID);
    endfunction

    function automatic bank_cfg_t decode_code(input logic [3:0] code,
                                              input logic       divided,
                                              input logic       hh_invert);
        bank_cfg_t c;
        int        idx;
        idx    = 3 * lvl_val(code[3:2]) + lvl_val(code[1:0]);
        c.mode = MODE_SKEW;
        c.skew = 4'(idx - 4);
        if (divided) begin
            c.skew = 4'(2 * (idx - 4));
            if (idx == 0) begin
                c.mode = MODE_DIV2;
                c.skew = 4'sd0;
            end else if (idx == 8) begin
                c.mode = hh_invert ? MODE_INV : MODE_DIV4;
                c.skew = 4'sd0;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/clkskew_period.sv
module clkskew_period
    import clkskew_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    range_in,
    output logic [CW-1:0] cnt,
    output logic [1:0]    pcnt,
    output logic          wrap,
    output logic [CW-1:0] mask,
    output logic [CW:0]   half
);
    logic [1:0] range_act;
    logic [CW:0] mf;

    assign mf   = ticks_of(range_act);
    assign wrap = ({1'b0, cnt} == mf - 1'b1);
    assign mask = mf[CW-1:0] - 1'b1;
    assign half = mf >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            pcnt      <= '0;
            range_act <= range_in;
        end else if (wrap) begin
            cnt       <= '0;
            pcnt      <= pcnt + 1'b1;
            range_act <= range_in;
        end else begin
            cnt       <= cnt + 1'b1;
        end
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt} < mf);

    a_r9_range_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(range_act));

    a_r5_period_step: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (pcnt == $past(pcnt) + 2'd1) && (cnt == '0));

    a_r6_period_steady: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(pcnt));

endmodule

// File: rtl/clkskew_bank.sv
module clkskew_bank
    import clkskew_pkg::*;
#(
    parameter bit DIVIDED   = 1'b0,
    parameter bit HH_INVERT = 1'b0,
    parameter int OUTS      = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wrap,
    input  logic [3:0]      code_in,
    input  logic [CW-1:0]   cnt,
    input  logic [1:0]      pcnt,
    input  logic [CW-1:0]   mask,
    input  logic [CW:0]     half,
    output logic [OUTS-1:0] q
);
    logic [3:0]    code_act;
    bank_cfg_t     cfg;
    logic [CW-1:0] skew_ext;
    logic [CW-1:0] phase;
    logic          base_hi;
    logic          lvl;

    always_ff @(posedge clk) begin
        if (rst || wrap) code_act <= code_in;
    end

    assign cfg      = decode_code(code_act, DIVIDED, HH_INVERT);
    assign skew_ext = {{(CW-4){cfg.skew[3]}}, cfg.skew};
    assign phase    = (cnt - skew_ext) & mask;
    assign base_hi  = ({1'b0, phase} < half);

    always_comb begin
        case (cfg.mode)
            MODE_DIV2: lvl = ~pcnt[0];
            MODE_DIV4: lvl = ~pcnt[1];
            MODE_INV:  lvl = ~base_hi;
            default:   lvl = base_hi;
        endcase
    end

    assign q = {OUTS{lvl}};

    a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(code_act));

    a_r3_zero_rise: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_SKEW && cfg.skew == 4'sd0 && $rose(q[0])) |-> (cnt == '0));

    a_r5_div_steady: assert property (@(posedge clk) disable iff (rst)
        ((cfg.mode == MODE_DIV2 || cfg.mode == MODE_DIV4) && !wrap) |=> $stable(q[0]));

endmodule

// File: rtl/clkskew_top.sv
module clkskew_top
    import clkskew_pkg::*;
#(
    parameter int OUTS_PER_BANK = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  range_sel,
    input  logic [15:0] bank_code,
    output logic [7:0]  clk_out
);
    localparam int NB = 4;

    logic [CW-1:0] cnt;
    logic [1:0]    pcnt;
    logic          wrap;
    logic [CW-1:0] mask;
    logic [CW:0]   half;

    clkskew_period u_period (
        .clk      (clk),
        .rst      (rst),
        .range_in (range_sel),
        .cnt      (cnt),
        .pcnt     (pcnt),
        .wrap     (wrap),
        .mask     (mask),
        .half     (half)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        clkskew_bank #(
            .DIVIDED   (b >= 2),
            .HH_INVERT (b == 3),
            .OUTS      (OUTS_PER_BANK)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wrap    (wrap),
            .code_in (bank_code[4*b +: 4]),
            .cnt     (cnt),
            .pcnt    (pcnt),
            .mask    (mask),
            .half    (half),
            .q       (clk_out[OUTS_PER_BANK*b +: OUTS_PER_BANK])
        );
    end

endmodule

// File: tb/clkskew_top_tb_top.sv
`timescale 1ns/1ps
module clkskew_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  range_sel = 2'b00;
    logic [15:0] bank_code = 16'h5555;
    logic [7:0]  clk_out;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    string scen     = "R10";

    int m_tick = 0, m_per = 0, m_mf = 32;
    logic [3:0] m_code [4];
    bit m_valid = 0;

    clkskew_top dut_i (
        .clk(clk), .rst(rst), .range_sel(range_sel),
        .bank_code(bank_code), .clk_out(clk_out)
    );

    always #4 clk = ~clk;

    function automatic int dig(input logic [1:0] d);
        if (d == 2'b00) return 0;
        if (d == 2'b10) return 2;
        return 1;
    endfunction

    function automatic int mf_for(input logic [1:0] r);
        if (r == 2'b00) return 32;
        if (r == 2'b10) return 8;
        return 16;
    endfunction

    function automatic bit expect_lvl(input int b, input logic [3:0] code,
                                      input int tick, input int per, input int mf);
        int idx, s, ph;
        idx = 3 * dig(code[3:2]) + dig(code[1:0]);
        if (b < 2) s = idx - 4;
        else begin
            if (idx == 0) return (per % 2) == 0;
            if (idx == 8) begin
                if (b == 2) return (per % 4) < 2;
                return !(tick < mf / 2);
            end
            s = 2 * (idx - 4);
        end
        ph = ((tick - s) % mf + mf) % mf;
        return ph < mf / 2;
    endfunction

    function automatic string rule_of(input int b, input logic [3:0] code);
        int idx;
        idx = 3 * dig(code[3:2]) + dig(code[1:0]);
        if (b < 2) return "R3";
        if (idx == 0) return "R5";
        if (idx == 8) return (b == 2) ? "R6" : "R7";
        return "R4";
    endfunction

    always @(posedge clk) begin
        #2;
        cycles++;
        if (rst) begin
            m_tick = 0; m_per = 0; m_mf = mf_for(range_sel);
            for (int b = 0; b < 4; b++) m_code[b] = bank_code[4*b +: 4];
            m_valid = 1;
        end else if (m_tick == m_mf - 1) begin
            m_tick = 0; m_per = (m_per + 1) % 4; m_mf = mf_for(range_sel);
            for (int b = 0; b < 4; b++) m_code[b] = bank_code[4*b +: 4];
        end else begin
            m_tick++;
        end
        if (m_valid) begin
            for (int b = 0; b < 4; b++) begin
                bit e;
                e = expect_lvl(b, m_code[b], m_tick, m_per, m_mf);
                n_checks++;
                if (clk_out[2*b] !== e) begin
                    n_errors++;
                    $display("FAIL %s/%s bank%0d out0 tick=%0d code=%b: actual=%b expected=%b",
                             rule_of(b, m_code[b]), scen, b, m_tick, m_code[b], clk_out[2*b], e);
                end
                n_checks++;
                if (clk_out[2*b+1] !== e) begin
                    n_errors++;
                    $display("FAIL R8/%s bank%0d out1 tick=%0d: actual=%b expected=%b",
                             scen, b, m_tick, clk_out[2*b+1], e);
                end
            end
        end
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] code_of(input int idx);
        logic [1:0] hi, lo;
        hi = (idx / 3 == 0) ? 2'b00 : (idx / 3 == 1) ? 2'b01 : 2'b10;
        lo = (idx % 3 == 0) ? 2'b00 : (idx % 3 == 1) ? 2'b01 : 2'b10;
        return {hi, lo};
    endfunction

    initial begin
        // R10: reset, all banks zero skew, long range
        wait_ticks(3);
        rst = 1'b0;
        wait_ticks(64);
        // R2/R3/R4/R5/R6/R7: sweep every code index under each range
        for (int r = 0; r < 3; r++) begin
            range_sel = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
            scen = "R2";
            for (int i = 0; i < 9; i++) begin
                bank_code = {code_of(i), code_of(8 - i), code_of(i), code_of((i + 3) % 9)};
                wait_ticks(5 * 32);
            end
        end
        // R1: spare digit 2'b11 treated as mid
        scen = "R1";
        range_sel = 2'b11;
        bank_code = {4'b1111, 4'b0011, 4'b1100, 4'b1110};
        wait_ticks(4 * 32);
        // R9: mid-period changes of codes and range
        scen = "R9";
        range_sel = 2'b00;
        wait_ticks(40);
        for (int k = 0; k < 6; k++) begin
            wait_ticks(7 + 3 * k);
            bank_code = {code_of(k), code_of(8 - k), code_of((k + 5) % 9), code_of(k + 2)};
            if (k == 3) range_sel = 2'b10;
            if (k == 5) range_sel = 2'b01;
            wait_ticks(9);
        end
        wait_ticks(64);
        // R10: reset in the middle of a run, new settings taken at once
        scen = "R10";
        wait_ticks(5);
        rst = 1'b1;
        bank_code = 16'h5555;
        range_sel = 2'b10;
        wait_ticks(2);
        rst = 1'b0;
        wait_ticks(40);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule